// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 30-bit physical address by reading a two-level page table. The table lives in an external memory that is addressed in words. The upper 8 bits of the virtual address pick an entry in the outer table, whose base comes from `root_base`. A valid outer entry gives the 30-bit word address of an inner table. The next 12 bits of the virtual address pick an entry in that inner table. A valid inner entry gives an 18-bit physical page number. The walker joins that page number with the 12-bit page offset, which passes through unchanged. Each entry index is scaled by `ENTRY_WORDS`, the number of words in one entry.

The walker makes the two lookups one after the other through a memory read port. It sends one request pulse and then waits, for as long as needed, until the matching response arrives. A table entry is 31 bits wide. Bit 30 is the valid bit and bits 29:0 carry the payload. An outer entry uses the whole payload as the table address. An inner entry uses bits 17:0 as the page number. If the valid bit is clear at either level, the walk stops and the response reports a page fault together with the level that failed. The walker takes one translation at a time and shows this on `busy`.

Top module: `ptw_walker`

## Requirements
- R1: While `rst` is high, and in the first cycle after it drops, `busy`, `mem_req_valid` and `rsp_valid` are 0.
- R2: If `req_valid` is high while `busy` is 0, then in the next cycle `busy` is 1 and `mem_req_valid` is 1 with `mem_req_addr` = `root_base` + `req_vaddr[31:24]` * `ENTRY_WORDS`.
- R3: `mem_req_valid` is high for exactly one cycle per lookup and stays low while the walker waits for that lookup's response.
- R4: A response whose bit 30 is 1, received in the outer lookup, causes the inner request in the next cycle, with address `data[29:0]` + `vaddr[23:12]` * `ENTRY_WORDS`.
- R5: A response whose bit 30 is 1, received in the inner lookup, causes `rsp_valid` = 1 in the next cycle, with `rsp_fault` = 0, `rsp_fault_level` = 0 and `rsp_paddr` = {`data[17:0]`, `vaddr[11:0]`}.
- R6: A response whose bit 30 is 0, received in the outer lookup, causes `rsp_valid` = 1 with `rsp_fault` = 1 and `rsp_fault_level` = 0 in the next cycle, and no inner request is made.
- R7: A response whose bit 30 is 0, received in the inner lookup, causes `rsp_valid` = 1 with `rsp_fault` = 1 and `rsp_fault_level` = 1 in the next cycle.
- R8: A lookup waits any number of cycles for its response. A `mem_rsp_valid` that comes while idle, or in the cycle `mem_req_valid` is high, is ignored.
- R9: `req_valid` is ignored while `busy` is 1. `busy` stays 1 through the cycle where `rsp_valid` is 1 and drops in the cycle after it.
- R10: `rsp_valid` is a single-cycle pulse, given once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| root_base | input | 30 | Word address of the outer table |
| req_valid | input | 1 | Translation request, taken only when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | High from acceptance through the response cycle |
| mem_req_valid | output | 1 | One-cycle memory read request |
| mem_req_addr | output | 30 | Word address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read data is present |
| mem_rsp_data | input | 31 | Table entry: bit 30 valid, bits 29:0 payload |
| rsp_valid | output | 1 | One-cycle translation result |
| rsp_fault | output | 1 | Page fault |
| rsp_fault_level | output | 1 | Failing level on a fault: 0 outer, 1 inner |
| rsp_paddr | output | 30 | Physical address when there is no fault |

## Verification
Two things can land on the same clock edge. The first is a new translation request arriving in the cycle the walker delivers a response. The second is a memory response arriving in the cycle its own request goes out. The bench drives `req_valid` in the exact cycle `rsp_valid` is high, and also keeps it high during a pending outer lookup. It then checks that no memory request follows, and that the inner address still comes from the first address. The bench also returns an outer entry in the same cycle as the request pulse, and returns one while the walker is idle. In both cases it checks that no inner request and no response appear. A later, properly timed response must still finish the walk.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2,
    ST_DONE  = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Entry address = table base + index scaled by entry size in words.
module ptw_addr_gen #(
  parameter int AW          = 30,
  parameter int IDX_W       = 12,
  parameter int ENTRY_WORDS = 1
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    addr
);
  localparam bit POW2 = ((ENTRY_WORDS & (ENTRY_WORDS - 1)) == 0);
  localparam int SH   = $clog2(ENTRY_WORDS);

  generate
    if (POW2) begin : g_shift
      assign addr = base + (AW'(idx) << SH);
    end else begin : g_mult
      assign addr = base + AW'(idx) * AW'(ENTRY_WORDS);
    end
  endgenerate
endmodule

// File: rtl/ptw_entry_decode.sv
// Splits a table word into its valid flag and the two payload views.
module ptw_entry_decode #(
  parameter int AW    = 30,
  parameter int PPN_W = 18
) (
  input  logic [AW:0]      word,
  output logic             ent_valid,
  output logic [AW-1:0]    ent_tbl,
  output logic [PPN_W-1:0] ent_ppn
);
  assign ent_valid = word[AW];
  assign ent_tbl   = word[AW-1:0];
  assign ent_ppn   = word[PPN_W-1:0];
endmodule

// File: rtl/ptw_ctrl.sv
// Walk sequencer: all outputs registered.
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int AW      = 30,
  parameter int PPN_W   = 18,
  parameter int INNER_W = 12,
  parameter int OFF_W   = 12,
  localparam int HOLD_W = INNER_W + OFF_W,
  localparam int PA_W   = PPN_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [HOLD_W-1:0] req_low,
  input  logic [AW-1:0]     outer_addr,
  input  logic [AW-1:0]     inner_addr,
  input  logic              mem_rsp_valid,
  input  logic              ent_valid,
  input  logic [PPN_W-1:0]  ent_ppn,
  output logic [HOLD_W-1:0] held_low,
  output logic              busy,
  output logic              mem_req_valid,
  output logic [AW-1:0]     mem_req_addr,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_fault_level,
  output logic [PA_W-1:0]   rsp_paddr
);
  walk_state_e state;
  logic        rsp_take;

  // A response only counts after the request pulse has ended.
  assign rsp_take = mem_rsp_valid && !mem_req_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= ST_IDLE;
      held_low        <= '0;
      busy            <= 1'b0;
      mem_req_valid   <= 1'b0;
      mem_req_addr    <= '0;
      rsp_valid       <= 1'b0;
      rsp_fault       <= 1'b0;
      rsp_fault_level <= 1'b0;
      rsp_paddr       <= '0;
    end else begin
      mem_req_valid <= 1'b0;
      rsp_valid     <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            held_low      <= req_low;
            busy          <= 1'b1;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= outer_addr;
            state         <= ST_OUTER;
          end
        end
        ST_OUTER: begin
          if (rsp_take) begin
            if (ent_valid) begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= inner_addr;
              state         <= ST_INNER;
            end else begin
              rsp_valid       <= 1'b1;
              rsp_fault       <= 1'b1;
              rsp_fault_level <= 1'b0;
              rsp_paddr       <= '0;
              state           <= ST_DONE;
            end
          end
        end
        ST_INNER: begin
          if (rsp_take) begin
            rsp_valid       <= 1'b1;
            rsp_fault       <= !ent_valid;
            rsp_fault_level <= !ent_valid;
            rsp_paddr       <= ent_valid ? {ent_ppn, held_low[OFF_W-1:0]} : '0;
            state           <= ST_DONE;
          end
        end
        default: begin
          busy  <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int OUTER_W     = 8,
  parameter int INNER_W     = 12,
  parameter int OFF_W       = 12,
  parameter int AW          = 30,
  parameter int PPN_W       = 18,
  parameter int ENTRY_WORDS = 1,
  localparam int VA_W       = OUTER_W + INNER_W + OFF_W,
  localparam int PA_W       = PPN_W + OFF_W,
  localparam int DW         = AW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   root_base,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            busy,
  output logic            mem_req_valid,
  output logic [AW-1:0]   mem_req_addr,
  input  logic            mem_rsp_valid,
  input  logic [DW-1:0]   mem_rsp_data,
  output logic            rsp_valid,
  output logic            rsp_fault,
  output logic            rsp_fault_level,
  output logic [PA_W-1:0] rsp_paddr
);
  localparam int HOLD_W = INNER_W + OFF_W;

  logic [AW-1:0]     outer_addr;
  logic [AW-1:0]     inner_addr;
  logic [HOLD_W-1:0] held_low;
  logic              ent_valid;
  logic [AW-1:0]     ent_tbl;
  logic [PPN_W-1:0]  ent_ppn;

  ptw_addr_gen #(.AW(AW), .IDX_W(OUTER_W), .ENTRY_WORDS(ENTRY_WORDS)) outer_gen_i (
    .base (root_base),
    .idx  (req_vaddr[VA_W-1 -: OUTER_W]),
    .addr (outer_addr)
  );

  ptw_addr_gen #(.AW(AW), .IDX_W(INNER_W), .ENTRY_WORDS(ENTRY_WORDS)) inner_gen_i (
    .base (ent_tbl),
    .idx  (held_low[HOLD_W-1 -: INNER_W]),
    .addr (inner_addr)
  );

  ptw_entry_decode #(.AW(AW), .PPN_W(PPN_W)) dec_i (
    .word      (mem_rsp_data),
    .ent_valid (ent_valid),
    .ent_tbl   (ent_tbl),
    .ent_ppn   (ent_ppn)
  );

  ptw_ctrl #(.AW(AW), .PPN_W(PPN_W), .INNER_W(INNER_W), .OFF_W(OFF_W)) ctrl_i (
    .clk             (clk),
    .rst             (rst),
    .req_valid       (req_valid),
    .req_low         (req_vaddr[HOLD_W-1:0]),
    .outer_addr      (outer_addr),
    .inner_addr      (inner_addr),
    .mem_rsp_valid   (mem_rsp_valid),
    .ent_valid       (ent_valid),
    .ent_ppn         (ent_ppn),
    .held_low        (held_low),
    .busy            (busy),
    .mem_req_valid   (mem_req_valid),
    .mem_req_addr    (mem_req_addr),
    .rsp_valid       (rsp_valid),
    .rsp_fault       (rsp_fault),
    .rsp_fault_level (rsp_fault_level),
    .rsp_paddr       (rsp_paddr)
  );
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic busy,
  input logic mem_req_valid,
  input logic mem_rsp_valid,
  input logic rsp_valid
);
  // R2
  accept_starts_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> (busy && mem_req_valid));

  // R3
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |=> !mem_req_valid);

  // R3
  req_only_when_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> busy);

  // R8
  idle_rsp_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && mem_rsp_valid) |=> !rsp_valid);

  // R9
  rsp_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> busy);

  // R9
  busy_drop_after_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(rsp_valid));

  // R10
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
endmodule

bind ptw_walker ptw_walker_chk chk_i (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_rsp_valid (mem_rsp_valid),
  .rsp_valid     (rsp_valid)
);

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] root_base = 30'h100;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        busy, mem_req_valid, rsp_valid, rsp_fault, rsp_fault_level;
  logic [29:0] mem_req_addr, rsp_paddr;
  logic        mem_rsp_valid = 1'b0;
  logic [30:0] mem_rsp_data = '0;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ptw_walker dut_i (
    .clk(clk), .rst(rst), .root_base(root_base),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_fault_level(rsp_fault_level), .rsp_paddr(rsp_paddr)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [30:0] outer_ent(input bit v, input logic [29:0] tbl);
    return {v, tbl};
  endfunction

  function automatic logic [30:0] inner_ent(input bit v, input logic [17:0] ppn);
    return {v, 12'h000, ppn};
  endfunction

  // Return one response after lat idle cycles; mem_req_valid must stay low meanwhile.
  task automatic serve(input int lat, input logic [30:0] data);
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      chk("R3", "mem_req_valid while waiting", mem_req_valid, 0);
    end
    @(negedge clk);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
  endtask

  task automatic start(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "busy after accept", busy, 1);
    chk("R2", "outer request", mem_req_valid, 1);
    chk("R2", "outer address", mem_req_addr, root_base + 30'(va[31:24]));
  endtask

  task automatic finish_walk();
    @(negedge clk);
    chk("R10", "rsp_valid pulse ends", rsp_valid, 0);
    chk("R9", "busy drops after response", busy, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "mem_req_valid in reset", mem_req_valid, 0);
    chk("R1", "rsp_valid in reset", rsp_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "rsp_valid after reset", rsp_valid, 0);
  endtask

  task automatic t_walk_ok(input logic [31:0] va, input logic [29:0] tbl,
                           input logic [17:0] ppn, input int l1, input int l2);
    start(va);
    serve(l1, outer_ent(1'b1, tbl));
    chk("R4", "inner request", mem_req_valid, 1);
    chk("R4", "inner address", mem_req_addr, tbl + 30'(va[23:12]));
    chk("R4", "no response yet", rsp_valid, 0);
    serve(l2, inner_ent(1'b1, ppn));
    chk("R5", "rsp_valid", rsp_valid, 1);
    chk("R5", "rsp_fault", rsp_fault, 0);
    chk("R5", "rsp_fault_level", rsp_fault_level, 0);
    chk("R5", "rsp_paddr", rsp_paddr, {ppn, va[11:0]});
    chk("R9", "busy during response", busy, 1);
    finish_walk();
  endtask

  task automatic t_fault_outer();
    start(32'h7A123456);
    serve(3, 31'h3FFFFFFF);
    chk("R6", "rsp_valid", rsp_valid, 1);
    chk("R6", "rsp_fault", rsp_fault, 1);
    chk("R6", "rsp_fault_level", rsp_fault_level, 0);
    chk("R6", "no inner request", mem_req_valid, 0);
    finish_walk();
    chk("R6", "still no request", mem_req_valid, 0);
  endtask

  task automatic t_fault_inner();
    start(32'h01FFF001);
    serve(1, outer_ent(1'b1, 30'h00050000));
    chk("R4", "inner address", mem_req_addr, 30'h00050FFF);
    serve(2, inner_ent(1'b0, 18'h3FFFF));
    chk("R7", "rsp_valid", rsp_valid, 1);
    chk("R7", "rsp_fault", rsp_fault, 1);
    chk("R7", "rsp_fault_level", rsp_fault_level, 1);
    finish_walk();
  endtask

  // New request in the response cycle, and while a lookup is pending.
  task automatic t_busy_collide();
    start(32'h05010020);
    req_valid = 1'b1;
    req_vaddr = 32'hAAFFF000;
    serve(2, outer_ent(1'b1, 30'h00001000));
    chk("R9", "inner address uses first request", mem_req_addr, 30'h00001010);
    req_valid = 1'b0;
    serve(0, inner_ent(1'b1, 18'h00123));
    chk("R5", "rsp_paddr", rsp_paddr, {18'h00123, 12'h020});
    req_valid = 1'b1;
    req_vaddr = 32'h11111111;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "busy low, request in response cycle dropped", busy, 0);
    chk("R9", "no memory request after drop", mem_req_valid, 0);
    @(negedge clk);
    chk("R9", "still idle", busy, 0);
  endtask

  // Response coinciding with the request pulse, then a stray one while idle.
  task automatic t_stray_rsp();
    start(32'h02000000);
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = outer_ent(1'b1, 30'h00002000);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R8", "early response no inner request", mem_req_valid, 0);
    chk("R8", "early response no result", rsp_valid, 0);
    chk("R8", "still busy", busy, 1);
    serve(5, outer_ent(1'b0, 30'h0));
    chk("R8", "late response accepted", rsp_valid, 1);
    chk("R6", "level after late response", rsp_fault_level, 0);
    finish_walk();
    mem_rsp_valid = 1'b1;
    mem_rsp_data  = inner_ent(1'b1, 18'h00055);
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R8", "idle response no result", rsp_valid, 0);
    chk("R8", "idle response stays idle", busy, 0);
    @(negedge clk);
    chk("R8", "idle response no result later", rsp_valid, 0);
  endtask

  initial begin
    t_reset();
    t_walk_ok(32'h03045ABC, 30'h00002000, 18'h1F0E3, 1, 0);
    t_walk_ok(32'hFFFFF123, 30'h00000F80, 18'h3FFFF, 0, 7);
    root_base = 30'h3FFFFF00;
    t_walk_ok(32'h00000FFF, 30'h12345000, 18'h00001, 4, 2);
    root_base = 30'h100;
    t_fault_outer();
    t_fault_inner();
    t_busy_collide();
    t_stray_rsp();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule